// File: doc/BRIEF.md
# Paired-Page Permission Checker

This block takes one translation entry that a lookup stage has already matched and checks a memory access against it. The entry covers two neighbouring pages, an even one and an odd one. Each page has its own frame number, valid flag, dirty flag, read-inhibit flag and execute-inhibit flag. The block picks the page that the access falls in. It applies the permission rules in a fixed order and returns either a translated physical address or a signed fault code.

The caller drives a one-cycle request strobe together with the address, the page mask, the access kind and the entry fields. One cycle later the block registers the result and pulses a done flag. Between requests the registered result holds its value. The three per-page flags can describe a read-only page (dirty clear), a write-only page (read-inhibit set) or a no-execute page (execute-inhibit set).

Top module: `tlbchk_pair`

## Requirements
- R1: The page is selected by the highest set bit of the page mask. When the address has that bit set, the odd page's flags and frame number are used. Otherwise the even page's are used.
- R2: A request with `miss` high yields code -2 (4'b1110), whatever the per-page fields hold.
- R3: When the selected page's valid flag is clear, the result is code -3 (4'b1101) for every access kind.
- R4: A fetch (`acc_kind` = 2'b10) to a valid page whose execute-inhibit flag is set yields code -6 (4'b1010).
- R5: A load (`acc_kind` = 2'b00), or the reserved kind 2'b11 treated as a load, to a valid page whose read-inhibit flag is set yields code -5 (4'b1011). Read-inhibit has no effect on stores or fetches, and execute-inhibit has no effect on loads.
- R6: A store (`acc_kind` = 2'b01) to a valid page whose dirty flag is clear yields code -4 (4'b1100). The dirty flag has no effect on loads or fetches.
- R7: When no fault applies, the code is 0 and `paddr` equals the selected frame number ORed with the address bits under the page mask shifted right by one.
- R8: `paddr` is zero whenever a nonzero code is reported.
- R9: `done` is high in exactly the cycle after each request. Without a request, `fault_code` and `paddr` keep their values.
- R10: A synchronous active-high reset clears `done`, `fault_code` and `paddr`.
- R11: The checks apply in this priority: miss, then invalid, then execute-inhibit or read-inhibit, then dirty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Request strobe, one cycle per access |
| miss | input | 1 | Upstream lookup reported no hit |
| vaddr | input | AW | Virtual address of the access |
| pmask | input | AW | Page mask, contiguous ones from bit 0; top set bit picks the page |
| acc_kind | input | 2 | 00 load, 01 store, 10 fetch, 11 reserved (load) |
| pg_valid | input | 2 | Valid flag, [0] even page, [1] odd page |
| pg_dirty | input | 2 | Dirty (writable) flag per page |
| pg_rinh | input | 2 | Read-inhibit flag per page |
| pg_xinh | input | 2 | Execute-inhibit flag per page |
| pfn_even | input | AW | Frame base of the even page, aligned to the page |
| pfn_odd | input | AW | Frame base of the odd page, aligned to the page |
| done | output | 1 | Result valid, one cycle after a request |
| fault_code | output | 4 | Signed result: 0 ok, -2 miss, -3 invalid, -4 dirty, -5 read-inhibit, -6 execute-inhibit |
| paddr | output | AW | Translated address, zero on a fault |

## Verification
The assertions assume that `pmask` is a contiguous run of ones starting at bit 0. They also assume that both frame numbers have zeros in every bit the mask covers, so the OR that builds the address never merges frame bits with offset bits. The stimulus builds every mask as 2^k-1 for a few page sizes. It clears the low k bits of both frame numbers before driving them. For each mask it sweeps all combinations of the access kind, the miss flag and the four per-page flag pairs, and it exercises both halves of the pair by forcing the select bit of the address.

// File: rtl/tlbchk_pkg.sv
package tlbchk_pkg;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'b00,
    ACC_STORE = 2'b01,
    ACC_FETCH = 2'b10,
    ACC_RSVD  = 2'b11
  } acc_e;

  typedef logic signed [3:0] code_t;

  localparam code_t CODE_OK      = 4'sb0000;
  localparam code_t CODE_NOMATCH = 4'sb1110;  // -2
  localparam code_t CODE_INVALID = 4'sb1101;  // -3
  localparam code_t CODE_DIRTY   = 4'sb1100;  // -4
  localparam code_t CODE_RINH    = 4'sb1011;  // -5
  localparam code_t CODE_XINH    = 4'sb1010;  // -6

  typedef struct packed {
    logic valid;
    logic dirty;
    logic rinh;
    logic xinh;
  } pgflags_t;

  // Loads include the reserved kind.
  function automatic logic is_load(acc_e kind);
    return (kind == ACC_LOAD) || (kind == ACC_RSVD);
  endfunction

  // Fixed-priority permission judgement on one selected page.
  function automatic code_t judge(logic miss, acc_e kind, pgflags_t f);
    code_t r;
    if (miss)                                r = CODE_NOMATCH;
    else if (!f.valid)                       r = CODE_INVALID;
    else if (kind == ACC_FETCH && f.xinh)    r = CODE_XINH;
    else if (is_load(kind) && f.rinh)        r = CODE_RINH;
    else if (kind == ACC_STORE && !f.dirty)  r = CODE_DIRTY;
    else                                     r = CODE_OK;
    return r;
  endfunction

endpackage

// File: rtl/tlbchk_half_sel.sv
module tlbchk_half_sel #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] vaddr,
  input  logic [AW-1:0] pmask,
  input  logic [AW-1:0] pfn_even,
  input  logic [AW-1:0] pfn_odd,
  output logic          sel_odd,
  output logic [AW-1:0] pa_cand
);

  // Isolate the top bit of the mask and test it in the address.
  function automatic logic pick_odd(logic [AW-1:0] va, logic [AW-1:0] m);
    return |(va & m & ~(m >> 1));
  endfunction

  // Offset bits that pass straight through to the physical address.
  function automatic logic [AW-1:0] offset_of(logic [AW-1:0] va, logic [AW-1:0] m);
    return va & (m >> 1);
  endfunction

  logic [AW-1:0] frame_sel;

  always_comb begin
    sel_odd   = pick_odd(vaddr, pmask);
    frame_sel = sel_odd ? pfn_odd : pfn_even;
    pa_cand   = frame_sel | offset_of(vaddr, pmask);
  end

endmodule

// File: rtl/tlbchk_rule_eval.sv
module tlbchk_rule_eval
  import tlbchk_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          miss,
  input  logic [1:0]    acc_kind,
  input  logic          sel_odd,
  input  logic [1:0]    pg_valid,
  input  logic [1:0]    pg_dirty,
  input  logic [1:0]    pg_rinh,
  input  logic [1:0]    pg_xinh,
  input  logic [AW-1:0] pa_cand,
  output code_t         code,
  output logic [AW-1:0] pa_next
);

  pgflags_t flags;
  acc_e     kind;

  always_comb begin
    kind        = acc_e'(acc_kind);
    flags.valid = pg_valid[sel_odd];
    flags.dirty = pg_dirty[sel_odd];
    flags.rinh  = pg_rinh[sel_odd];
    flags.xinh  = pg_xinh[sel_odd];
    code        = judge(miss, kind, flags);
    pa_next     = (code == CODE_OK) ? pa_cand : '0;
  end

endmodule

// File: rtl/tlbchk_result_reg.sv
module tlbchk_result_reg
  import tlbchk_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  code_t         code_in,
  input  logic [AW-1:0] pa_in,
  output logic          done,
  output code_t         code_q,
  output logic [AW-1:0] pa_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      done   <= 1'b0;
      code_q <= CODE_OK;
      pa_q   <= '0;
    end else begin
      done <= req;
      if (req) begin
        code_q <= code_in;
        pa_q   <= pa_in;
      end
    end
  end

endmodule

// File: rtl/tlbchk_pair.sv
module tlbchk_pair
  import tlbchk_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  logic          miss,
  input  logic [AW-1:0] vaddr,
  input  logic [AW-1:0] pmask,
  input  logic [1:0]    acc_kind,
  input  logic [1:0]    pg_valid,
  input  logic [1:0]    pg_dirty,
  input  logic [1:0]    pg_rinh,
  input  logic [1:0]    pg_xinh,
  input  logic [AW-1:0] pfn_even,
  input  logic [AW-1:0] pfn_odd,
  output logic          done,
  output logic [3:0]    fault_code,
  output logic [AW-1:0] paddr
);

  // Named internal events, visible to the bound checker.
  logic          sel_odd;
  logic [AW-1:0] pa_cand;
  code_t         eval_code;
  logic [AW-1:0] pa_next;
  code_t         code_q;

  tlbchk_half_sel #(.AW(AW)) u_half (
    .vaddr    (vaddr),
    .pmask    (pmask),
    .pfn_even (pfn_even),
    .pfn_odd  (pfn_odd),
    .sel_odd  (sel_odd),
    .pa_cand  (pa_cand)
  );

  tlbchk_rule_eval #(.AW(AW)) u_rules (
    .miss     (miss),
    .acc_kind (acc_kind),
    .sel_odd  (sel_odd),
    .pg_valid (pg_valid),
    .pg_dirty (pg_dirty),
    .pg_rinh  (pg_rinh),
    .pg_xinh  (pg_xinh),
    .pa_cand  (pa_cand),
    .code     (eval_code),
    .pa_next  (pa_next)
  );

  tlbchk_result_reg #(.AW(AW)) u_reg (
    .clk     (clk),
    .rst     (rst),
    .req     (req),
    .code_in (eval_code),
    .pa_in   (pa_next),
    .done    (done),
    .code_q  (code_q),
    .pa_q    (paddr)
  );

  assign fault_code = code_q;

endmodule

// File: rtl/tlbchk_pair_chk.sv
module tlbchk_pair_chk
  import tlbchk_pkg::*;
#(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          req,
  input logic          miss,
  input logic [1:0]    acc_kind,
  input logic [1:0]    pg_valid,
  input logic [1:0]    pg_dirty,
  input logic [1:0]    pg_rinh,
  input logic [1:0]    pg_xinh,
  input logic          sel_odd,
  input logic          done,
  input logic [3:0]    fault_code,
  input logic [AW-1:0] paddr
);

  logic live;
  assign live = req && !miss && pg_valid[sel_odd];

  // R9
  done_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
    req |=> done);

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !req |=> !done && $stable(fault_code) && $stable(paddr));

  // R2
  miss_code_chk: assert property (@(posedge clk) disable iff (rst)
    req && miss |=> fault_code == CODE_NOMATCH);

  // R3
  invalid_code_chk: assert property (@(posedge clk) disable iff (rst)
    req && !miss && !pg_valid[sel_odd] |=> fault_code == CODE_INVALID);

  // R4
  xinh_code_chk: assert property (@(posedge clk) disable iff (rst)
    live && acc_kind == 2'b10 && pg_xinh[sel_odd] |=> fault_code == CODE_XINH);

  // R5
  rinh_code_chk: assert property (@(posedge clk) disable iff (rst)
    live && !acc_kind[1] == 1'b0 && acc_kind[0] && pg_rinh[sel_odd]
    |=> fault_code == CODE_RINH);

  // R5
  rinh_load_chk: assert property (@(posedge clk) disable iff (rst)
    live && acc_kind == 2'b00 && pg_rinh[sel_odd] |=> fault_code == CODE_RINH);

  // R6
  dirty_code_chk: assert property (@(posedge clk) disable iff (rst)
    live && acc_kind == 2'b01 && !pg_dirty[sel_odd] |=> fault_code == CODE_DIRTY);

  // R8
  fault_zero_pa_chk: assert property (@(posedge clk) disable iff (rst)
    done && fault_code != 4'b0000 |-> paddr == '0);

  // R10
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> !done && fault_code == 4'b0000 && paddr == '0);

endmodule

bind tlbchk_pair tlbchk_pair_chk #(.AW(AW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req        (req),
  .miss       (miss),
  .acc_kind   (acc_kind),
  .pg_valid   (pg_valid),
  .pg_dirty   (pg_dirty),
  .pg_rinh    (pg_rinh),
  .pg_xinh    (pg_xinh),
  .sel_odd    (sel_odd),
  .done       (done),
  .fault_code (fault_code),
  .paddr      (paddr)
);

// File: tb/test_tlbchk_pair.sv
module test_tlbchk_pair;

  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst;
  logic          req;
  logic          miss;
  logic [AW-1:0] vaddr;
  logic [AW-1:0] pmask;
  logic [1:0]    acc_kind;
  logic [1:0]    pg_valid, pg_dirty, pg_rinh, pg_xinh;
  logic [AW-1:0] pfn_even, pfn_odd;
  logic          done;
  logic [3:0]    fault_code;
  logic [AW-1:0] paddr;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  tlbchk_pair #(.AW(AW)) i_tlbchk_pair (
    .clk(clk), .rst(rst), .req(req), .miss(miss), .vaddr(vaddr), .pmask(pmask),
    .acc_kind(acc_kind), .pg_valid(pg_valid), .pg_dirty(pg_dirty),
    .pg_rinh(pg_rinh), .pg_xinh(pg_xinh), .pfn_even(pfn_even), .pfn_odd(pfn_odd),
    .done(done), .fault_code(fault_code), .paddr(paddr)
  );

  task automatic chk(string tag, logic [AW-1:0] act, logic [AW-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
    end
  end

  initial begin
    int pages[3] = '{1, 13, 25};
    int iter = 0;
    rst = 1'b1; req = 1'b0; miss = 1'b0; vaddr = '0; pmask = '0; acc_kind = '0;
    pg_valid = '0; pg_dirty = '0; pg_rinh = '0; pg_xinh = '0;
    pfn_even = '0; pfn_odd = '0;
    repeat (3) @(negedge clk);
    // R10: outputs after reset
    chk("R10 done", {31'b0, done}, '0);
    chk("R10 code", {28'b0, fault_code}, '0);
    chk("R10 paddr", paddr, '0);
    rst = 1'b0;

    foreach (pages[pi]) begin
      for (int ms = 0; ms < 2; ms++)
      for (int ak = 0; ak < 4; ak++)
      for (int v = 0; v < 4; v++)
      for (int d = 0; d < 4; d++)
      for (int ri = 0; ri < 4; ri++)
      for (int xi = 0; xi < 4; xi++) begin
        int k = pages[pi];
        logic [AW-1:0] lowmask;
        logic [AW-1:0] va;
        logic [AW-1:0] fe, fo, fsel, exp_pa;
        logic odd, inv, xhit, rhit, dhit, is_ld;
        logic [3:0] exp_code;
        string tag;
        lowmask = (AW'(1) << k) - 1;
        va  = 32'hA5C3_1F7B ^ (AW'(iter) * 32'h9E37_79B9);
        odd = iter[0] ^ iter[3];
        va[k-1] = odd;  // force the half-select bit
        fe = (32'h1234_5000 + AW'(iter) * 32'h0100_0000) & ~lowmask;
        fo = (32'h8765_4000 ^ (AW'(iter) << 20)) & ~lowmask;

        @(negedge clk);
        req = 1'b1; miss = ms[0]; vaddr = va; pmask = lowmask;
        acc_kind = ak[1:0]; pg_valid = v[1:0]; pg_dirty = d[1:0];
        pg_rinh = ri[1:0]; pg_xinh = xi[1:0]; pfn_even = fe; pfn_odd = fo;

        // Expected result from the requirements.
        is_ld = (ak == 0) || (ak == 3);
        inv  = !v[odd];
        xhit = (ak == 2) && xi[odd];
        rhit = is_ld && ri[odd];
        dhit = (ak == 1) && !d[odd];
        fsel = odd ? fo : fe;
        exp_pa = '0;
        if (ms[0])      begin exp_code = 4'b1110; tag = "R2"; end
        else if (inv)   begin exp_code = 4'b1101; tag = (xhit|rhit|dhit) ? "R3 R11" : "R3"; end
        else if (xhit)  begin exp_code = 4'b1010; tag = "R4"; end
        else if (rhit)  begin exp_code = 4'b1011; tag = "R5"; end
        else if (dhit)  begin exp_code = 4'b1100; tag = "R6"; end
        else begin
          exp_code = 4'b0000;
          exp_pa   = fsel + (va % (AW'(1) << (k - 1)));
          tag      = odd ? "R1 R7 odd" : "R1 R7 even";
        end

        @(negedge clk);
        req = 1'b0;
        chk({tag, " code"}, {28'b0, fault_code}, {28'b0, exp_code});
        chk((exp_code == 0) ? {tag, " paddr"} : "R8 paddr", paddr, exp_pa);
        chk("R9 done", {31'b0, done}, 32'd1);

        if (iter % 16 == 0) begin
          // R9: idle cycle with changed inputs leaves the result alone
          miss = ~miss; pg_valid = ~pg_valid; vaddr = ~vaddr;
          @(negedge clk);
          chk("R9 idle done", {31'b0, done}, '0);
          chk("R9 idle code", {28'b0, fault_code}, {28'b0, exp_code});
          chk("R9 idle paddr", paddr, exp_pa);
        end
        iter++;
      end
    end

    // R10: reset clears a nonzero result
    @(negedge clk);
    req = 1'b1; miss = 1'b1;
    @(negedge clk);
    req = 1'b0; rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R10 code after rst", {28'b0, fault_code}, '0);
    chk("R10 done after rst", {31'b0, done}, '0);

    finished = 1'b1;
    summary();
  end

endmodule